// File: doc/BRIEF.md
# Dual-Rate Interrupt Timebase

This block derives two periodic events from a single system clock. A fast accumulation event marks each point at which firmware should collect correlation results. A slower measurement tick (TIC) marks each point at which new measurement data becomes available. Each event raises its own interrupt line. The TIC also produces a one-clock `tic_pulse` strobe. A processor-interface mode input selects the sense of both interrupt lines.

Firmware programs both periods through a small register port. The accumulation period is held in one register. The TIC period spans two 16-bit registers: the high half is only staged, and writing the low half commits both halves together. A period change never disturbs the interval that is already running. It takes effect at the next boundary of its own counter.

On each accumulation interrupt, firmware polls two status words. Status A reports fresh accumulated data. Status B holds a sticky TIC flag and a sticky flag for missed accumulations. Reading a status word clears its flags and deasserts the matching interrupt. At 40 MHz the reset periods of 20202 and 2,000,000 cycles correspond to about 505 µs and 50 ms.

Top module: `dual_rate_timebase`

## Requirements
- R1: In reset and immediately after it, both interrupts are inactive, `tic_pulse` is low and both status words read 0. The accumulation period register (address 0) reads ACC_RESET (default 20202). The TIC high register (address 1) reads the upper 16 bits of TIC_RESET (default 2,000,000), and the TIC low register (address 2) reads its lower 16 bits.
- R2: Counting clock edges after reset release, accumulation events occur at cycle ACC_RESET and then once every programmed period. A write to address 0 takes effect from the next accumulation event onward.
- R3: The TIC period is {high (address 1), low (address 2)}. Writing address 1 only stages the high half, and readback of address 1 returns the staged value. Writing address 2 commits the staged high half together with the written low half. Readback of address 2 returns the committed low half.
- R4: The first TIC follows TIC_RESET cycles after reset release. A committed TIC period applies from the next TIC onward; the interval already running is not changed.
- R5: Any period value below 2 behaves as 2. `tic_pulse` is exactly one clock wide.
- R6: `tic_pulse` is high in the first cycle in which the measurement interrupt is active. The measurement interrupt becomes active only together with `tic_pulse`.
- R7: Status A (address 3) bit 0 is set by each accumulation event and cleared by a read of address 3. The accumulation interrupt is active exactly while that bit is set. A status read returns the value held before the read clears it.
- R8: Status B (address 4) bit 0 is a sticky TIC flag and bit 1 is a sticky missed-accumulation flag. A read of address 4 clears both bits. The measurement interrupt is active exactly while bit 0 is set.
- R9: The missed-accumulation flag sets when an accumulation event arrives while status A bit 0 is still set and is not being read in that same cycle. When an event coincides with a read of address 3, the event wins: bit 0 stays set and no miss is recorded.
- R10: With `irq_active_low` = 1 both interrupt lines drive 0 when active and 1 when inactive. With `irq_active_low` = 0 they are active high.
- R11: Read data appears on `reg_rdata` in the cycle after `reg_rd_en`. Addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_active_low | input | 1 | Interrupt sense: 1 = active low, 0 = active high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| acc_irq | output | 1 | Accumulation interrupt |
| meas_irq | output | 1 | Measurement interrupt |
| tic_pulse | output | 1 | One-clock strobe at each TIC |

## Verification
The properties assume that `irq_active_low` changes only while reset is held, because they judge "active" from the line level and the current sense. They also assume that no period below 2 is programmed while `tic_pulse` is being watched for width. The stimulus therefore changes the sense only inside a second reset phase, and in that phase it programs a TIC period of 1, which the block must treat as 2. Read strobes are single-cycle. A status read is deliberately placed on the same edge as an accumulation event, so that the rule that an event beats a clearing read is exercised against the missed-accumulation flag.

// File: rtl/dual_rate_timebase_pkg.sv
// Package: shared widths, register addresses and status bit positions
// for the dual-rate interrupt timebase.
package dual_rate_timebase_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;
    localparam int TIC_W  = 2 * DATA_W;

    typedef enum logic [ADDR_W-1:0] {
        REG_ACC_PERIOD = 3'd0,
        REG_TIC_HI     = 3'd1,
        REG_TIC_LO     = 3'd2,
        REG_STAT_A     = 3'd3,
        REG_STAT_B     = 3'd4
    } reg_addr_e;

    localparam int SA_READY  = 0;
    localparam int SB_TIC    = 0;
    localparam int SB_MISSED = 1;
endpackage

// File: rtl/drt_period_counter.sv
// Module: drt_period_counter
// Repeating down-counter. It fires once every period_i cycles. The period
// is sampled only when the count reaches zero, so a new value never cuts
// short the interval already running. Values below 2 act as 2.
// Assumes RESET_PERIOD >= 2.
module drt_period_counter #(
    parameter int             W            = 16,
    parameter logic [W-1:0]   RESET_PERIOD = W'(2)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] period_i,
    output logic         fire_o,
    output logic         tick_o
);
    localparam logic [W-1:0] MIN_PERIOD = W'(2);

    logic [W-1:0] cnt_q;
    logic [W-1:0] eff_period;

    // Clamp the programmed period to the smallest supported interval.
    always_comb eff_period = (period_i < MIN_PERIOD) ? MIN_PERIOD : period_i;

    assign fire_o = (cnt_q == '0);

    // Count down; on reaching zero reload from the current period and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= RESET_PERIOD - W'(1);
            tick_o <= 1'b0;
        end else begin
            tick_o <= fire_o;
            cnt_q  <= fire_o ? (eff_period - W'(1)) : (cnt_q - W'(1));
        end
    end
endmodule

// File: rtl/drt_regfile.sv
// Module: drt_regfile
// Period registers. The accumulation period is written directly. The TIC
// period is staged high-half first and committed whole on a low-half write.
// Assumes ACC_W <= DATA_W.
module drt_regfile
    import dual_rate_timebase_pkg::*;
#(
    parameter int                ACC_W     = 16,
    parameter logic [ACC_W-1:0]  ACC_RESET = ACC_W'(2),
    parameter logic [TIC_W-1:0]  TIC_RESET = TIC_W'(2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [ACC_W-1:0]  acc_period_o,
    output logic [TIC_W-1:0]  tic_period_o,
    output logic [DATA_W-1:0] tic_stage_o
);
    // Register writes; the committed TIC value changes only on a low-half write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_period_o <= ACC_RESET;
            tic_period_o <= TIC_RESET;
            tic_stage_o  <= TIC_RESET[TIC_W-1:DATA_W];
        end else if (wr_en) begin
            case (addr)
                REG_ACC_PERIOD: acc_period_o <= wdata[ACC_W-1:0];
                REG_TIC_HI:     tic_stage_o  <= wdata;
                REG_TIC_LO:     tic_period_o <= {tic_stage_o, wdata};
                default:        ;
            endcase
        end
    end
endmodule

// File: rtl/drt_status.sv
// Module: drt_status
// Sticky status flags. An event beats a clearing read in the same cycle.
// The miss flag records an accumulation event that lands on unread data.
module drt_status
    import dual_rate_timebase_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_fire,
    input  logic              tic_fire,
    input  logic              rd_a,
    input  logic              rd_b,
    output logic [DATA_W-1:0] stat_a,
    output logic [DATA_W-1:0] stat_b,
    output logic              acc_flag,
    output logic              tic_flag
);
    logic missed_q;

    // Accumulation-ready flag: set by an event, cleared by a status A read.
    always_ff @(posedge clk) begin
        if (!rst_n)        acc_flag <= 1'b0;
        else if (acc_fire) acc_flag <= 1'b1;
        else if (rd_a)     acc_flag <= 1'b0;
    end

    // Missed flag: event on unread data; cleared by a status B read.
    always_ff @(posedge clk) begin
        if (!rst_n)                             missed_q <= 1'b0;
        else if (acc_fire && acc_flag && !rd_a) missed_q <= 1'b1;
        else if (rd_b)                          missed_q <= 1'b0;
    end

    // TIC flag: set by each TIC, cleared by a status B read.
    always_ff @(posedge clk) begin
        if (!rst_n)        tic_flag <= 1'b0;
        else if (tic_fire) tic_flag <= 1'b1;
        else if (rd_b)     tic_flag <= 1'b0;
    end

    // Pack the flags into the two status words.
    always_comb begin
        stat_a            = '0;
        stat_a[SA_READY]  = acc_flag;
        stat_b            = '0;
        stat_b[SB_TIC]    = tic_flag;
        stat_b[SB_MISSED] = missed_q;
    end
endmodule

// File: rtl/dual_rate_timebase.sv
// Module: dual_rate_timebase (top)
// Two programmable periodic events with sticky status and interrupts of
// selectable sense. Register reads are registered, one cycle of latency.
// Assumes irq_active_low is static outside reset.
module dual_rate_timebase
    import dual_rate_timebase_pkg::*;
#(
    parameter int                ACC_W     = 16,
    parameter logic [ACC_W-1:0]  ACC_RESET = ACC_W'(20202),
    parameter logic [TIC_W-1:0]  TIC_RESET = TIC_W'(2000000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_active_low,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              acc_irq,
    output logic              meas_irq,
    output logic              tic_pulse
);
    logic [ACC_W-1:0]  acc_period;
    logic [TIC_W-1:0]  tic_period;
    logic [DATA_W-1:0] tic_stage;
    logic              acc_fire, acc_tick, tic_fire;
    logic              rd_a, rd_b;
    logic [DATA_W-1:0] stat_a, stat_b;
    logic              acc_flag, tic_flag;

    assign rd_a = reg_rd_en && (reg_addr == REG_STAT_A);
    assign rd_b = reg_rd_en && (reg_addr == REG_STAT_B);

    drt_regfile #(
        .ACC_W(ACC_W), .ACC_RESET(ACC_RESET), .TIC_RESET(TIC_RESET)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .acc_period_o(acc_period),
        .tic_period_o(tic_period), .tic_stage_o(tic_stage)
    );

    drt_period_counter #(.W(ACC_W), .RESET_PERIOD(ACC_RESET)) u_acc_cnt (
        .clk(clk), .rst_n(rst_n), .period_i(acc_period),
        .fire_o(acc_fire), .tick_o(acc_tick)
    );

    drt_period_counter #(.W(TIC_W), .RESET_PERIOD(TIC_RESET)) u_tic_cnt (
        .clk(clk), .rst_n(rst_n), .period_i(tic_period),
        .fire_o(tic_fire), .tick_o(tic_pulse)
    );

    drt_status u_status (
        .clk(clk), .rst_n(rst_n), .acc_fire(acc_fire), .tic_fire(tic_fire),
        .rd_a(rd_a), .rd_b(rd_b), .stat_a(stat_a), .stat_b(stat_b),
        .acc_flag(acc_flag), .tic_flag(tic_flag)
    );

    // Apply the selected interrupt sense.
    assign acc_irq  = acc_flag ^ irq_active_low;
    assign meas_irq = tic_flag ^ irq_active_low;

    // Registered read mux; unmapped addresses return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd_en) begin
            case (reg_addr)
                REG_ACC_PERIOD: reg_rdata <= DATA_W'(acc_period);
                REG_TIC_HI:     reg_rdata <= tic_stage;
                REG_TIC_LO:     reg_rdata <= tic_period[DATA_W-1:0];
                REG_STAT_A:     reg_rdata <= stat_a;
                REG_STAT_B:     reg_rdata <= stat_b;
                default:        reg_rdata <= '0;
            endcase
        end
    end

    // The registered accumulation strobe has no consumer at this level.
    logic unused_ok;
    assign unused_ok = acc_tick;
endmodule

// File: rtl/drt_checker.sv
// Module: drt_checker
// Temporal checks on the timebase ports, bound to the top module.
// Assumes irq_active_low is constant outside reset.
module drt_checker
    import dual_rate_timebase_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              irq_active_low,
    input logic              reg_rd_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              acc_irq,
    input logic              meas_irq,
    input logic              tic_pulse
);
    logic acc_act, meas_act;
    assign acc_act  = acc_irq ^ irq_active_low;
    assign meas_act = meas_irq ^ irq_active_low;

    // R5
    a_r5_tic_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        tic_pulse |=> !tic_pulse);

    // R6
    a_r6_tic_sets_meas: assert property (@(posedge clk) disable iff (!rst_n)
        tic_pulse |-> meas_act);

    // R6
    a_r6_meas_rise_on_tic: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(meas_act) |-> tic_pulse);

    // R7
    a_r7_acc_clears_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_act) |-> $past(reg_rd_en && (reg_addr == REG_STAT_A)));

    // R8
    a_r8_meas_clears_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(meas_act) |-> $past(reg_rd_en && (reg_addr == REG_STAT_B)));
endmodule

bind dual_rate_timebase drt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .irq_active_low(irq_active_low),
    .reg_rd_en(reg_rd_en), .reg_addr(reg_addr), .acc_irq(acc_irq),
    .meas_irq(meas_irq), .tic_pulse(tic_pulse)
);

// File: tb/dual_rate_timebase_bench.sv
// Scoreboard bench: driver tasks queue expected read data and event cycles,
// and a monitor compares them on falling edges.
module dual_rate_timebase_bench;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int WD_CYCLES = 60000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_active_low = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        acc_irq, meas_irq, tic_pulse;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    bit    rd_seen = 1'b0;
    bit    acc_prev = 1'b0;
    bit    done = 1'b0;
    int    exp_tic_q[$];
    int    exp_acc_q[$];
    int    exp_rd_q[$];
    string rd_tag_q[$];

    always #2 clk = ~clk;

    dual_rate_timebase #(.TIC_RESET(32'd3000)) u_dual_rate_timebase (
        .clk(clk), .rst_n(rst_n), .irq_active_low(irq_active_low),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_irq(acc_irq),
        .meas_irq(meas_irq), .tic_pulse(tic_pulse)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0; else cyc <= cyc + 1;
        rd_seen <= rst_n && reg_rd_en;
    end

    // Monitor: compare read data and event timing against the queues.
    always @(negedge clk) begin
        bit acc_now;
        if (!rst_n) begin
            acc_prev = 1'b0;
        end else begin
            if (rd_seen) begin
                if (exp_rd_q.size() == 0) chk("R11 unexpected read", int'(reg_rdata), -1);
                else chk(rd_tag_q.pop_front(), int'(reg_rdata), exp_rd_q.pop_front());
            end
            if (tic_pulse) begin
                if (exp_tic_q.size() == 0) chk("R4 unexpected TIC", cyc, -1);
                else chk("R4/R5 TIC cycle", cyc, exp_tic_q.pop_front());
            end
            acc_now = acc_irq ^ irq_active_low;
            if (acc_now && !acc_prev) begin
                if (exp_acc_q.size() == 0) chk("R2 unexpected accumulation irq", cyc, -1);
                else chk("R2/R7 accumulation irq cycle", cyc, exp_acc_q.pop_front());
            end
            acc_prev = acc_now;
        end
    end

    task automatic at(input int c);
        @(negedge clk);
        while (cyc < c) @(negedge clk);
        #1;
    endtask

    task automatic rd(input logic [2:0] a, input int e, input string tag);
        reg_rd_en = 1'b1; reg_addr = a;
        exp_rd_q.push_back(e); rd_tag_q.push_back(tag);
        @(negedge clk); #1;
        reg_rd_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic finish_run();
        chk("R4 TIC events left", exp_tic_q.size(), 0);
        chk("R2 accumulation events left", exp_acc_q.size(), 0);
        chk("R11 reads left", exp_rd_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(WD_CYCLES * 4);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // Phase 1: active-high interrupts.
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        exp_tic_q.push_back(3000); exp_tic_q.push_back(3500);
        exp_tic_q.push_back(4000); exp_tic_q.push_back(4500);
        exp_tic_q.push_back(10500); exp_tic_q.push_back(16500);
        exp_acc_q.push_back(20202); exp_acc_q.push_back(20302);
        exp_acc_q.push_back(20502); exp_acc_q.push_back(20602);
        at(1);
        chk("R1 acc_irq after reset", acc_irq, 0);
        chk("R1 meas_irq after reset", meas_irq, 0);
        chk("R1 tic_pulse after reset", tic_pulse, 0);
        at(2);
        rd(3'd3, 0, "R1 status A reset");
        rd(3'd4, 0, "R1 status B reset");
        rd(3'd0, 20202, "R1 acc period reset");
        rd(3'd1, 0, "R1 TIC high reset");
        rd(3'd2, 3000, "R1 TIC low reset");
        at(8);
        chk("R10 acc_irq inactive high-sense", acc_irq, 0);
        at(10);
        wr(3'd1, 16'd0);
        wr(3'd2, 16'd500);
        rd(3'd2, 500, "R3 TIC low committed");
        wr(3'd0, 16'd100);
        rd(3'd0, 100, "R2 acc period readback");
        rd(3'd1, 0, "R3 TIC high staged");
        at(3010);
        rd(3'd4, 1, "R8 status B TIC set");
        rd(3'd4, 0, "R8 status B cleared by read");
        at(3012);
        chk("R8 meas_irq cleared by read", meas_irq, 0);
        at(3200);
        wr(3'd1, 16'd7);
        rd(3'd2, 500, "R3 high write alone does not commit");
        rd(3'd1, 7, "R3 staged high readback");
        at(3500);
        chk("R6 tic_pulse at TIC", tic_pulse, 1);
        chk("R6 meas_irq active with TIC", meas_irq, 1);
        at(4100);
        wr(3'd1, 16'd0);
        wr(3'd2, 16'd6000);
        rd(3'd2, 6000, "R3 TIC low recommitted");
        at(17000);
        rd(3'd4, 1, "R8 sticky TIC flag");
        rd(3'd4, 0, "R8 TIC flag cleared");
        at(20100);
        chk("R7 acc_irq idle before first event", acc_irq, 0);
        at(20250);
        rd(3'd3, 1, "R7 status A ready");
        at(20260);
        chk("R7 acc_irq cleared by read", acc_irq, 0);
        at(20410);
        rd(3'd4, 2, "R9 missed flag set");
        rd(3'd4, 0, "R9 missed flag cleared");
        at(20420);
        rd(3'd3, 1, "R7 status A before clear");
        at(20501);
        rd(3'd3, 0, "R9 read on event edge returns prior value");
        at(20505);
        chk("R9 event wins over clearing read", acc_irq, 1);
        at(20510);
        rd(3'd4, 0, "R9 no miss on coinciding read");
        rd(3'd3, 1, "R9 ready kept by event");
        at(20520);
        rd(3'd7, 0, "R11 unmapped address");
        at(20650);

        // Phase 2: active-low interrupts and minimum period.
        irq_active_low = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R10 acc_irq inactive low-sense", acc_irq, 1);
        chk("R10 meas_irq inactive low-sense", meas_irq, 1);
        chk("R1 tic_pulse in reset", tic_pulse, 0);
        rst_n = 1'b1;
        for (int t = 3000; t <= 3014; t += 2) exp_tic_q.push_back(t);
        at(4);
        rd(3'd2, 3000, "R1 TIC low restored by reset");
        rd(3'd0, 20202, "R1 acc period restored by reset");
        at(10);
        wr(3'd1, 16'd0);
        wr(3'd2, 16'd1);
        at(2990);
        chk("R10 meas_irq idle high in low-sense", meas_irq, 1);
        at(3001);
        chk("R10 meas_irq active low", meas_irq, 0);
        at(3015);
        finish_run();
    end
endmodule